// File: doc/BRIEF.md
# Type-Tagged Word Checker

This unit handles the type tags of a tagged-memory processor. Every word carries a 3-bit tag that marks it as null, a plain value, an address, a reference (an address paired with a value) or an instruction. The unit has three jobs, and each runs on its own each cycle.

First, it works out the tag of every ALU result from the two operand tags and the operation class. Second, it guards instruction fetch: it raises a fault when the fetched word is not tagged as an instruction, and it latches a halt. Third, it applies explicit tag writes from the dedicated tag instructions. The tag array and the ALU datapath sit outside the unit.

A tag write that marks a word as an instruction places that word's address in a small queue of translation-cache invalidation requests. The head of the queue is shown until the cache acknowledges it. Ordinary data moves never reach the unit, so they cannot change a tag.

Top module: `tag_guard`

## Requirements
- R1: While reset is high and in the cycle after it falls, res_valid, fetch_fault, halt, tmem_we and inval_valid are low and twr_ready is high.
- R2: An ALU result is null (code 0) when either operand tag is null (0) or an illegal code (5, 6 or 7). This rule overrides every other rule.
- R3: With op class ADD (alu_op=0), an address (2) and a value (1), in either order, give an address (2).
- R4: Two values (1, 1) give a value under any op class, and SUB (alu_op=1) of an address from an address (2, 2) gives a value (1).
- R5: Every other non-null combination gives a value (1). This includes reference or instruction operands, ADD of two addresses, and LOGIC (2) or SHIFT (3) on addresses. Codes are null=0, value=1, address=2, reference=3, instruction=4.
- R6: res_tag and res_valid appear one clock after alu_valid is sampled. ALU requests issued back to back give results back to back, in order.
- R7: A fetch with fetch_tag other than 4 pulses fetch_fault for one cycle, one clock later. A fetch tagged 4 gives no fault.
- R8: Halt sets together with the first fetch fault and stays set until reset.
- R9: An accepted tag write (twr_valid with twr_ready) drives tmem_we, tmem_addr and tmem_tag one clock later. Illegal codes 5 to 7 are written as 0.
- R10: An accepted write of tag 4 queues its address for invalidation. inval_valid and inval_addr hold steady until inval_ack, and queued addresses leave in the order they were written.
- R11: When DEPTH invalidations are pending, twr_ready is low and a presented write is neither applied nor queued. An acknowledge and a new queued write in the same cycle leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_valid | input | 1 | ALU operation issued this cycle |
| alu_op | input | 2 | Op class: 0 ADD, 1 SUB, 2 LOGIC, 3 SHIFT |
| opa_tag | input | 3 | Tag of the first operand |
| opb_tag | input | 3 | Tag of the second operand |
| res_valid | output | 1 | Result tag valid |
| res_tag | output | 3 | Computed result tag |
| fetch_valid | input | 1 | Instruction fetch this cycle |
| fetch_tag | input | 3 | Tag of the fetched word |
| fetch_fault | output | 1 | One-cycle fault pulse |
| halt | output | 1 | Sticky halt |
| twr_valid | input | 1 | Explicit tag write request |
| twr_ready | output | 1 | Tag write can be accepted |
| twr_addr | input | AW | Word address of the tag write |
| twr_tag | input | 3 | New tag |
| tmem_we | output | 1 | Tag array write enable |
| tmem_addr | output | AW | Tag array write address |
| tmem_tag | output | 3 | Cleaned tag to write |
| inval_valid | output | 1 | Invalidation request pending |
| inval_addr | output | AW | Address to invalidate |
| inval_ack | input | 1 | Cache accepted the head request |

## Verification
Two things can fall in the same cycle: the cache acknowledges the head invalidation, and a new write to tag 4 pushes onto the queue. The bench provokes this with one pending entry and again with three. The judgement is that the count stays the same, the next head is the older survivor, and drain order matches write order. The bench also fills the queue to DEPTH, then shows twr_ready low and confirms that the refused write reaches neither the tag array nor the queue. ALU traffic and fetch checks run alongside in those cycles.

// File: rtl/tag_guard_pkg.sv
package tag_guard_pkg;

  localparam int TAG_W = 3;
  localparam int OPC_W = 2;

  typedef enum logic [TAG_W-1:0] {
    TAG_NULL = 3'd0,
    TAG_VAL  = 3'd1,
    TAG_ADDR = 3'd2,
    TAG_REF  = 3'd3,
    TAG_INSN = 3'd4
  } tag_e;

  typedef enum logic [OPC_W-1:0] {
    OPC_ADD   = 2'd0,
    OPC_SUB   = 2'd1,
    OPC_LOGIC = 2'd2,
    OPC_SHIFT = 2'd3
  } opc_e;

  // Codes above the instruction code are illegal and read as null.
  function automatic tag_e tag_clean(input logic [TAG_W-1:0] raw);
    if (raw > TAG_W'(TAG_INSN)) return TAG_NULL;
    return tag_e'(raw);
  endfunction

endpackage

// File: rtl/tag_alu_rule.sv
module tag_alu_rule
  import tag_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             alu_valid,
  input  logic [OPC_W-1:0] alu_op,
  input  logic [TAG_W-1:0] opa_tag,
  input  logic [TAG_W-1:0] opb_tag,
  output logic             res_valid,
  output logic [TAG_W-1:0] res_tag
);

  tag_e a_t, b_t, rule_t;
  opc_e op_t;

  always_comb begin
    a_t  = tag_clean(opa_tag);
    b_t  = tag_clean(opb_tag);
    op_t = opc_e'(alu_op);
    if (a_t == TAG_NULL || b_t == TAG_NULL)
      rule_t = TAG_NULL;
    else if (op_t == OPC_ADD &&
             ((a_t == TAG_ADDR && b_t == TAG_VAL) ||
              (a_t == TAG_VAL && b_t == TAG_ADDR)))
      rule_t = TAG_ADDR;
    else
      rule_t = TAG_VAL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_tag   <= TAG_W'(TAG_NULL);
    end else begin
      res_valid <= alu_valid;
      if (alu_valid) res_tag <= rule_t;
    end
  end

  // R2
  null_prop_chk: assert property (@(posedge clk) disable iff (rst)
    (alu_valid && (opa_tag == 3'd0 || opb_tag == 3'd0)) |=> (res_tag == 3'd0));
  // R6
  res_follow_chk: assert property (@(posedge clk) disable iff (rst)
    alu_valid |=> res_valid);
  // R5
  res_legal_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_tag <= 3'd2));

endmodule

// File: rtl/tag_fetch_guard.sv
module tag_fetch_guard
  import tag_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             fetch_valid,
  input  logic [TAG_W-1:0] fetch_tag,
  output logic             fetch_fault,
  output logic             halt
);

  logic bad_fetch;

  always_comb bad_fetch = fetch_valid && (tag_clean(fetch_tag) != TAG_INSN);

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_fault <= 1'b0;
      halt        <= 1'b0;
    end else begin
      fetch_fault <= bad_fetch;
      if (bad_fetch) halt <= 1'b1;
    end
  end

  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halt |=> halt);
  // R8
  fault_halts_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_fault |-> halt);
  // R7
  good_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && fetch_tag == 3'd4) |=> !fetch_fault);

endmodule

// File: rtl/tag_write_port.sv
module tag_write_port
  import tag_guard_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_accept,
  input  logic [AW-1:0]    wr_addr,
  input  logic [TAG_W-1:0] wr_tag,
  output logic             tmem_we,
  output logic [AW-1:0]    tmem_addr,
  output logic [TAG_W-1:0] tmem_tag
);

  always_ff @(posedge clk) begin
    if (rst) begin
      tmem_we   <= 1'b0;
      tmem_addr <= '0;
      tmem_tag  <= TAG_W'(TAG_NULL);
    end else begin
      tmem_we <= wr_accept;
      if (wr_accept) begin
        tmem_addr <= wr_addr;
        tmem_tag  <= tag_clean(wr_tag);
      end
    end
  end

  // R9
  clean_write_chk: assert property (@(posedge clk) disable iff (rst)
    tmem_we |-> (tmem_tag <= 3'd4));
  // R9
  write_lat_chk: assert property (@(posedge clk) disable iff (rst)
    wr_accept |=> (tmem_we && tmem_addr == $past(wr_addr)));

endmodule

// File: rtl/tag_inval_queue.sv
module tag_inval_queue #(
  parameter int AW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic          ack,
  output logic          full,
  output logic          inval_valid,
  output logic [AW-1:0] inval_addr
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [AW-1:0]    q_mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  always_comb begin
    full        = (count == CNT_W'(DEPTH));
    inval_valid = (count != '0);
    inval_addr  = q_mem[rd_ptr];
    do_push     = push && !full;
    do_pop      = ack && inval_valid;
  end

  // Storage without reset so it can map onto RAM.
  always_ff @(posedge clk) begin
    if (do_push) q_mem[wr_ptr] <= push_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push)
        wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)
        rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
  // R10
  inval_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (inval_valid && !ack) |=> (inval_valid && $stable(inval_addr)));
  // R11
  swap_count_chk: assert property (@(posedge clk) disable iff (rst)
    (do_push && do_pop) |=> $stable(count));

endmodule

// File: rtl/tag_guard.sv
module tag_guard
  import tag_guard_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alu_valid,
  input  logic [1:0]    alu_op,
  input  logic [2:0]    opa_tag,
  input  logic [2:0]    opb_tag,
  output logic          res_valid,
  output logic [2:0]    res_tag,
  input  logic          fetch_valid,
  input  logic [2:0]    fetch_tag,
  output logic          fetch_fault,
  output logic          halt,
  input  logic          twr_valid,
  output logic          twr_ready,
  input  logic [AW-1:0] twr_addr,
  input  logic [2:0]    twr_tag,
  output logic          tmem_we,
  output logic [AW-1:0] tmem_addr,
  output logic [2:0]    tmem_tag,
  output logic          inval_valid,
  output logic [AW-1:0] inval_addr,
  input  logic          inval_ack
);

  logic q_full, wr_accept, insn_push;

  always_comb begin
    twr_ready = !q_full;
    wr_accept = twr_valid && !q_full;
    insn_push = wr_accept && (tag_clean(twr_tag) == TAG_INSN);
  end

  tag_alu_rule u_alu (
    .clk(clk), .rst(rst), .alu_valid(alu_valid), .alu_op(alu_op),
    .opa_tag(opa_tag), .opb_tag(opb_tag),
    .res_valid(res_valid), .res_tag(res_tag)
  );

  tag_fetch_guard u_fetch (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_tag(fetch_tag),
    .fetch_fault(fetch_fault), .halt(halt)
  );

  tag_write_port #(.AW(AW)) u_wr (
    .clk(clk), .rst(rst), .wr_accept(wr_accept), .wr_addr(twr_addr),
    .wr_tag(twr_tag), .tmem_we(tmem_we), .tmem_addr(tmem_addr),
    .tmem_tag(tmem_tag)
  );

  tag_inval_queue #(.AW(AW), .DEPTH(DEPTH)) u_invq (
    .clk(clk), .rst(rst), .push(insn_push), .push_addr(twr_addr),
    .ack(inval_ack), .full(q_full), .inval_valid(inval_valid),
    .inval_addr(inval_addr)
  );

  // R10
  insn_queues_chk: assert property (@(posedge clk) disable iff (rst)
    (twr_valid && twr_ready && twr_tag == 3'd4) |=> inval_valid);
  // R11
  refused_write_chk: assert property (@(posedge clk) disable iff (rst)
    (twr_valid && !twr_ready) |=> !tmem_we);

endmodule

// File: tb/tag_guard_bench.sv
module tag_guard_bench;

  localparam int AW    = 16;
  localparam int DEPTH = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          alu_valid = 1'b0;
  logic [1:0]    alu_op = '0;
  logic [2:0]    opa_tag = '0, opb_tag = '0;
  logic          res_valid;
  logic [2:0]    res_tag;
  logic          fetch_valid = 1'b0;
  logic [2:0]    fetch_tag = '0;
  logic          fetch_fault, halt;
  logic          twr_valid = 1'b0;
  logic          twr_ready;
  logic [AW-1:0] twr_addr = '0;
  logic [2:0]    twr_tag = '0;
  logic          tmem_we;
  logic [AW-1:0] tmem_addr;
  logic [2:0]    tmem_tag;
  logic          inval_valid;
  logic [AW-1:0] inval_addr;
  logic          inval_ack = 1'b0;

  always #5 clk = ~clk;

  tag_guard #(.AW(AW), .DEPTH(DEPTH)) u_tag_guard (.*);

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit halt_exp = 1'b0;

  logic [2:0]    res_q [$];
  int            rid_q [$];
  logic [AW-1:0] mem_addr_q [$];
  logic [2:0]    mem_tag_q [$];
  logic [AW-1:0] inv_q [$];

  task automatic chk(input bit ok, input int rid, input string what,
                     input longint got, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d: %s got %0d exp %0d", rid, what, got, exp);
    end
  endtask

  // Spec model of the ALU tag rules; returns tag and requirement id.
  function automatic logic [2:0] rule(input logic [1:0] op, input logic [2:0] a,
                                      input logic [2:0] b, output int rid);
    if (a == 0 || b == 0 || a > 4 || b > 4) begin rid = 2; return 3'd0; end // R2
    if (a == 1 && b == 1) begin rid = 4; return 3'd1; end                  // R4
    if (op == 0 && ((a == 2 && b == 1) || (a == 1 && b == 2))) begin
      rid = 3; return 3'd2;                                                 // R3
    end
    if (op == 1 && a == 2 && b == 2) begin rid = 4; return 3'd1; end       // R4
    rid = 5; return 3'd1;                                                   // R5
  endfunction

  // Monitor: pops scoreboard entries as results appear.
  always @(negedge clk) begin
    if (!rst) begin
      if (res_valid) begin
        if (res_q.size() == 0) chk(1'b0, 6, "unexpected res_valid", 1, 0);
        else begin
          chk(res_tag == res_q[0], rid_q[0], "res_tag", res_tag, res_q[0]);
          void'(res_q.pop_front());
          void'(rid_q.pop_front());
        end
      end
      if (tmem_we) begin
        if (mem_addr_q.size() == 0) chk(1'b0, 9, "unexpected tmem_we", 1, 0);
        else begin
          chk(tmem_addr == mem_addr_q[0], 9, "tmem_addr", tmem_addr, mem_addr_q[0]);
          chk(tmem_tag == mem_tag_q[0], 9, "tmem_tag", tmem_tag, mem_tag_q[0]);
          void'(mem_addr_q.pop_front());
          void'(mem_tag_q.pop_front());
        end
      end
    end
  end

  // Driver: one cycle of stimulus, called just after a rising edge.
  task automatic step(input bit av, input logic [1:0] op, input logic [2:0] a,
                      input logic [2:0] b, input bit fv, input logic [2:0] ft,
                      input bit wv, input logic [AW-1:0] wa, input logic [2:0] wt,
                      input bit ack);
    int rid;
    logic [2:0] et;
    logic [2:0] ct;
    bit rdy;
    rdy = (inv_q.size() < DEPTH);
    chk(twr_ready == rdy, 11, "twr_ready", twr_ready, rdy);
    chk(inval_valid == (inv_q.size() != 0), 10, "inval_valid", inval_valid, inv_q.size() != 0);
    if (ack && inv_q.size() != 0) begin
      chk(inval_addr == inv_q[0], 10, "inval_addr", inval_addr, inv_q[0]);
      void'(inv_q.pop_front());
    end
    alu_valid = av; alu_op = op; opa_tag = a; opb_tag = b;
    fetch_valid = fv; fetch_tag = ft;
    twr_valid = wv; twr_addr = wa; twr_tag = wt; inval_ack = ack;
    if (av) begin
      et = rule(op, a, b, rid);
      res_q.push_back(et);
      rid_q.push_back(rid);
    end
    if (wv && rdy) begin
      ct = (wt > 4) ? 3'd0 : wt;
      mem_addr_q.push_back(wa);
      mem_tag_q.push_back(ct);
      if (ct == 3'd4) inv_q.push_back(wa);
    end
    @(posedge clk);
    #1;
    alu_valid = 0; fetch_valid = 0; twr_valid = 0; inval_ack = 0;
    // R7 fault pulse and R8 sticky halt
    chk(fetch_fault == (fv && ft != 3'd4), 7, "fetch_fault", fetch_fault, fv && ft != 3'd4);
    if (fv && ft != 3'd4) halt_exp = 1'b1;
    chk(halt == halt_exp, 8, "halt", halt, halt_exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, '0, 0, 0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk); #1;
    // R1 outputs held low during reset
    chk(!res_valid && !fetch_fault && !halt && !tmem_we && !inval_valid && twr_ready,
        1, "outputs in reset", {res_valid, fetch_fault, halt, tmem_we, inval_valid}, 0);
    @(posedge clk); #1;
    rst = 1'b0;
    res_q.delete(); rid_q.delete(); mem_addr_q.delete(); mem_tag_q.delete(); inv_q.delete();
    halt_exp = 1'b0;
    @(posedge clk); #1;
    // R1 state after reset release
    chk(!res_valid && !fetch_fault && !halt && !tmem_we && !inval_valid && twr_ready,
        1, "outputs after reset", {res_valid, fetch_fault, halt, tmem_we, inval_valid}, 0);
  endtask

  initial begin
    do_reset();

    // R2 R3 R4 R5 R6: every op class and tag pair, back to back
    for (int op = 0; op < 4; op++)
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++)
          step(1, 2'(op), 3'(a), 3'(b), 0, 0, 0, '0, 0, 0);
    idle(2);

    // R7: good fetch, then bad fetch that also halts (R8)
    step(0, 0, 0, 0, 1, 3'd4, 0, '0, 0, 0);
    step(0, 0, 0, 0, 1, 3'd1, 0, '0, 0, 0);
    idle(3);
    step(0, 0, 0, 0, 1, 3'd4, 0, '0, 0, 0);
    step(0, 0, 0, 0, 1, 3'd6, 0, '0, 0, 0);
    idle(2);

    // R9: plain and illegal tag writes
    step(0, 0, 0, 0, 0, 0, 1, 16'h0010, 3'd1, 0);
    step(0, 0, 0, 0, 0, 0, 1, 16'h0011, 3'd6, 0);
    step(0, 0, 0, 0, 0, 0, 1, 16'h0012, 3'd3, 0);
    idle(2);

    // R10: one pending, then ack and new push in the same cycle (R11)
    step(0, 0, 0, 0, 0, 0, 1, 16'h0100, 3'd4, 0);
    idle(2);
    step(1, 0, 3'd2, 3'd1, 0, 0, 1, 16'h0101, 3'd4, 1);
    idle(1);
    step(0, 0, 0, 0, 0, 0, 0, '0, 0, 1);
    idle(1);

    // R11: fill to DEPTH, refused write, swap at depth three, drain in order
    step(0, 0, 0, 0, 0, 0, 1, 16'h0200, 3'd4, 0);
    step(0, 0, 0, 0, 0, 0, 1, 16'h0201, 3'd4, 0);
    step(0, 0, 0, 0, 0, 0, 1, 16'h0202, 3'd4, 0);
    step(0, 0, 0, 0, 0, 0, 1, 16'h0203, 3'd4, 0);
    step(0, 0, 0, 0, 0, 0, 1, 16'h0204, 3'd4, 0);
    step(0, 0, 0, 0, 0, 0, 1, 16'h0205, 3'd1, 0);
    step(0, 0, 0, 0, 0, 0, 0, '0, 0, 1);
    step(1, 1, 3'd2, 3'd2, 1, 3'd4, 1, 16'h0206, 3'd4, 1);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 0, 0, '0, 0, 1);
    idle(2);

    // R8: only reset clears halt
    do_reset();
    step(0, 0, 0, 0, 1, 3'd4, 0, '0, 0, 0);
    idle(2);

    chk(res_q.size() == 0 && mem_addr_q.size() == 0, 6, "leftover expectations",
        res_q.size() + mem_addr_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R6: watchdog expired got 0 exp 1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule